// File: doc/BRIEF.md
# Two-Counter Periodic Interval Timer

This block provides two periodic down-counters, called counter 0 and counter 2, that divide a slow reference tick by a programmable 16-bit value. The reference tick arrives as a one-cycle enable input (`ref_tick`) synchronous to the system clock. Software reaches the block through a single write port. A two-bit port select chooses between a shared control-word register and one data register for each counter.

A control word picks a counter and stores that counter's operating mode. Only low-byte-then-high-byte access is accepted; any other control word raises an error pulse. A 16-bit count is assembled from two data writes. One byte-order flag is shared by both data ports. The second write completes the value and starts the counter named by that write's port. The counter then expires every count reference ticks. Each expiry sets the counter's status byte and reloads the count automatically. Each expiry of counter 0 also produces a one-clock interrupt pulse. Counter 2's status byte is presented on an output for reading.

Top module: `interval_timer_top`

## Requirements
- R1: After reset, `irq0_o` and `ctrl_err_o` are 0, `status2_o` is 8'h00, both mode outputs are 0, and neither counter runs.
- R2: A control-word write (`wr_sel` = 0) stores bits 3:1 as the mode of the counter selected by bits 7:6 when bits 7:6 are 2'b00 (counter 0, `mode0_o`) or 2'b10 (counter 2, `mode2_o`) and bits 5:4 equal 2'b11. It raises no error.
- R3: A control word with bits 5:4 other than 2'b11, or with bits 7:6 equal to 2'b01 or 2'b11, pulses `ctrl_err_o` high for exactly one clock, starting at the edge that takes the write. Both modes stay unchanged.
- R4: Data writes go through `wr_sel` = 1 (counter 0) or `wr_sel` = 2 (counter 2). One byte-order flag is shared by both ports. The first write is kept as the low byte. The second write supplies the high byte and starts the counter of the port used by that second write. A write with `wr_sel` = 3 is ignored and does not disturb the flag.
- R5: A started counter expires after exactly count reference ticks. It then reloads and expires again every count ticks. Clock cycles without `ref_tick` do not advance it.
- R6: A programmed count of 0 gives a period of 65536 reference ticks.
- R7: Each expiry sets the counter's status byte to 8'h20. Starting a counter clears its status byte to 8'h00. `status2_o` shows counter 2's status byte.
- R8: Each expiry of counter 0 drives `irq0_o` high for one clock. Counter 2 never drives `irq0_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 control, 1 data counter 0, 2 data counter 2, 3 unused |
| wr_data | input | 8 | Write byte |
| irq0_o | output | 1 | Counter 0 expiry pulse |
| status2_o | output | 8 | Counter 2 status byte |
| ctrl_err_o | output | 1 | Unsupported control-word pulse |
| mode0_o | output | 3 | Stored mode of counter 0 |
| mode2_o | output | 3 | Stored mode of counter 2 |

## Verification
The assertions assume `ref_tick`, `wr_en` and `wr_sel` are known and settled at every rising clock edge. They also assume a write lasts exactly one clock. The bench drives all inputs only on falling edges and raises `wr_en` for a single cycle per byte. It holds `ref_tick` low during every write. This keeps the edge that loads a counter free of a simultaneous tick, so tick counts measured from that edge stay unambiguous.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [1:0] {
        PORT_CTRL  = 2'd0,
        PORT_DATA0 = 2'd1,
        PORT_DATA2 = 2'd2,
        PORT_NONE  = 2'd3
    } port_e;

    localparam int          MODE_W         = 3;
    localparam int          NUM_CNT        = 2;
    localparam logic [7:0]  STATUS_EXPIRED = 8'h20;
    localparam logic [1:0]  ACC_LOHI       = 2'b11;
    localparam logic [1:0]  SEL_CNT0       = 2'b00;
    localparam logic [1:0]  SEL_CNT2       = 2'b10;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_sel_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    output logic [NUM_CNT-1:0]    load_o,
    output logic [2*BYTE_W-1:0]   load_val_o,
    output logic [NUM_CNT-1:0]    mode_we_o,
    output logic [MODE_W-1:0]     mode_val_o,
    output logic                  err_o
);
    typedef struct packed {
        logic              pending;
        logic [BYTE_W-1:0] low;
        logic              err;
    } ctrl_s;

    ctrl_s s_d, s_q;
    port_e port;
    logic  ctrl_wr, word_ok;

    always_comb begin
        s_d        = s_q;
        s_d.err    = 1'b0;
        port       = port_e'(wr_sel_i);
        load_o     = '0;
        load_val_o = {wr_data_i, s_q.low};
        mode_we_o  = '0;
        mode_val_o = wr_data_i[MODE_W:1];
        ctrl_wr    = wr_en_i && (port == PORT_CTRL);
        word_ok    = (wr_data_i[5:4] == ACC_LOHI) &&
                     ((wr_data_i[7:6] == SEL_CNT0) || (wr_data_i[7:6] == SEL_CNT2));
        if (ctrl_wr) begin
            if (word_ok) begin
                mode_we_o[0] = (wr_data_i[7:6] == SEL_CNT0);
                mode_we_o[1] = (wr_data_i[7:6] == SEL_CNT2);
            end else begin
                s_d.err = 1'b1;
            end
        end
        if (wr_en_i && (port == PORT_DATA0 || port == PORT_DATA2)) begin
            if (s_q.pending) begin
                s_d.pending = 1'b0;
                load_o[0]   = (port == PORT_DATA0);
                load_o[1]   = (port == PORT_DATA2);
            end else begin
                s_d.pending = 1'b1;
                s_d.low     = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_o = s_q.err;

    a_r3_err_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en_i && wr_sel_i == PORT_CTRL));
    a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));
    a_r2_one_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_we_o));
    a_r4_load_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_o) |=> !s_q.pending);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [CW-1:0]     load_val_i,
    input  logic              mode_we_i,
    input  logic [MODE_W-1:0] mode_val_i,
    output logic              expire_o,
    output logic [7:0]        status_o,
    output logic [MODE_W-1:0] mode_o
);
    localparam int            RW   = CW + 1;
    localparam logic [RW-1:0] FULL = RW'(1) << CW;

    typedef struct packed {
        logic [RW-1:0]     remain;
        logic [RW-1:0]     period;
        logic              running;
        logic [7:0]        status;
        logic [MODE_W-1:0] mode;
        logic              pulse;
    } cnt_s;

    cnt_s          s_d, s_q;
    logic [RW-1:0] start_val;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        start_val = (load_val_i == '0) ? FULL : RW'(load_val_i);
        if (load_i) begin
            s_d.period  = start_val;
            s_d.remain  = start_val;
            s_d.running = 1'b1;
            s_d.status  = 8'h00;
        end else if (s_q.running && tick_i) begin
            if (s_q.remain == RW'(1)) begin
                s_d.remain = s_q.period;
                s_d.status = STATUS_EXPIRED;
                s_d.pulse  = 1'b1;
            end else begin
                s_d.remain = s_q.remain - RW'(1);
            end
        end
        if (mode_we_i) s_d.mode = mode_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expire_o = s_q.pulse;
    assign status_o = s_q.status;
    assign mode_o   = s_q.mode;

    a_r7_status_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> status_o == STATUS_EXPIRED);
    a_r7_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == 8'h00 || status_o == STATUS_EXPIRED);
    a_r5_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> s_q.remain != '0);
    a_r5_remain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> s_q.remain <= s_q.period);
    a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.running && !tick_i && !load_i) |=> $stable(s_q.remain));
    a_r5_expire_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(tick_i));
endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              irq0_o,
    output logic [7:0]        status2_o,
    output logic              ctrl_err_o,
    output logic [MODE_W-1:0] mode0_o,
    output logic [MODE_W-1:0] mode2_o
);
    localparam int CW = 2 * BYTE_W;

    logic [NUM_CNT-1:0]  load, mode_we, expire;
    logic [CW-1:0]       load_val;
    logic [MODE_W-1:0]   mode_val;
    logic [7:0]          status [NUM_CNT];
    logic [MODE_W-1:0]   mode   [NUM_CNT];

    pit_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .load_o     (load),
        .load_val_o (load_val),
        .mode_we_o  (mode_we),
        .mode_val_o (mode_val),
        .err_o      (ctrl_err_o)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pit_counter #(.CW(CW)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (ref_tick),
            .load_i     (load[i]),
            .load_val_i (load_val),
            .mode_we_i  (mode_we[i]),
            .mode_val_i (mode_val),
            .expire_o   (expire[i]),
            .status_o   (status[i]),
            .mode_o     (mode[i])
        );
    end

    assign irq0_o    = expire[0];
    assign status2_o = status[1];
    assign mode0_o   = mode[0];
    assign mode2_o   = mode[1];

    a_r8_irq_from_cnt0_load: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> !irq0_o);
    a_r3_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err_o |=> !ctrl_err_o || $past(wr_en && wr_sel == PORT_CTRL));
endmodule

// File: tb/sim_interval_timer_top.sv
module sim_interval_timer_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // each entry: {count[15:0], tick spacing in clocks[3:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {16'd1,   4'd1}, {16'd2,   4'd1}, {16'd7,   4'd1},
        {16'd300, 4'd1}, {16'd5,   4'd3}, {16'd4,   4'd2}
    };

    logic       clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq0_o, ctrl_err_o;
    logic [7:0] status2_o;
    logic [2:0] mode0_o, mode2_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit irq_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq0_o(irq0_o),
        .status2_o(status2_o), .ctrl_err_o(ctrl_err_o),
        .mode0_o(mode0_o), .mode2_o(mode2_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_tick = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        ref_tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts reference ticks until irq0_o is seen; -1 on timeout
    task automatic measure(input int div, input int lim, output int ticks);
        int n = 0;
        int ph = 0;
        ticks = 0;
        do begin
            ref_tick = (ph == 0);
            if (ref_tick) ticks++;
            ph = (ph + 1) % div;
            @(negedge clk);
            n++;
        end while (!irq0_o && n < lim);
        ref_tick = 1'b0;
        if (!irq0_o) ticks = -1;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            if (irq0_o) irq_seen = 1'b1;
        end
        ref_tick = 1'b0;
    endtask

    initial begin
        int t;
        do_reset();
        // R1 reset state
        chk(irq0_o == 0 && ctrl_err_o == 0, "R1 irq/err", {irq0_o, ctrl_err_o}, 0);
        chk(status2_o == 8'h00, "R1 status2", status2_o, 0);
        chk(mode0_o == 0 && mode2_o == 0, "R1 modes", {mode0_o, mode2_o}, 0);
        run_ticks(20);
        chk(status2_o == 8'h00 && irq0_o == 0, "R1 idle counters", status2_o, 0);

        // R5 table of counts and tick spacings, two periods each
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            wr(2'd0, 8'h34);
            wr(2'd1, VEC[v][11:4]);
            wr(2'd1, VEC[v][19:12]);
            measure(int'(VEC[v][3:0]), 5000, t);
            chk(t == int'(VEC[v][19:4]), "R5 first period", t, int'(VEC[v][19:4]));
            measure(int'(VEC[v][3:0]), 5000, t);
            chk(t == int'(VEC[v][19:4]), "R5 reload period", t, int'(VEC[v][19:4]));
        end

        // R6 count zero
        do_reset();
        wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        measure(1, 70000, t);
        chk(t == 65536, "R6 zero count", t, 65536);

        // R2 valid control words
        do_reset();
        wr(2'd0, 8'h36);
        chk(mode0_o == 3'd3 && mode2_o == 3'd0, "R2 mode0", mode0_o, 3);
        chk(ctrl_err_o == 0, "R2 no error", ctrl_err_o, 0);
        wr(2'd0, 8'hB4);
        chk(mode2_o == 3'd2 && mode0_o == 3'd3, "R2 mode2", mode2_o, 2);

        // R3 unsupported control words
        wr(2'd0, 8'h1E);
        chk(ctrl_err_o == 1, "R3 access bits", ctrl_err_o, 1);
        @(negedge clk);
        chk(ctrl_err_o == 0, "R3 one-clock pulse", ctrl_err_o, 0);
        wr(2'd0, 8'hFE);
        chk(ctrl_err_o == 1, "R3 readback select", ctrl_err_o, 1);
        wr(2'd0, 8'h7E);
        chk(ctrl_err_o == 1, "R3 counter1 select", ctrl_err_o, 1);
        chk(mode0_o == 3'd3 && mode2_o == 3'd2, "R3 modes kept", {mode0_o, mode2_o}, 8'o32);

        // R7 R8 counter 2 status, no irq
        do_reset();
        irq_seen = 1'b0;
        wr(2'd2, 8'd4); wr(2'd2, 8'd0);
        run_ticks(3);
        chk(status2_o == 8'h00, "R7 before expiry", status2_o, 0);
        run_ticks(1);
        chk(status2_o == 8'h20, "R7 after expiry", status2_o, 32);
        run_ticks(10);
        chk(!irq_seen, "R8 counter2 no irq", irq_seen, 0);
        wr(2'd2, 8'd9); wr(2'd2, 8'd0);
        chk(status2_o == 8'h00, "R7 cleared on start", status2_o, 0);

        // R4 shared byte-order flag across ports
        do_reset();
        irq_seen = 1'b0;
        wr(2'd1, 8'd2); wr(2'd2, 8'd0);
        run_ticks(2);
        chk(status2_o == 8'h20, "R4 cross-port start", status2_o, 32);
        run_ticks(6);
        chk(!irq_seen, "R4 counter0 not started", irq_seen, 0);

        // R4 port 3 ignored
        do_reset();
        wr(2'd1, 8'd3); wr(2'd3, 8'h55); wr(2'd1, 8'd0);
        measure(1, 5000, t);
        chk(t == 3, "R4 port 3 ignored", t, 3);
        @(negedge clk);
        chk(irq0_o == 0, "R8 irq one clock", irq0_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule